// File: doc/BRIEF.md
# Paged ROM Table-Read Sequencer

This block carries out the table-read instruction of a small 4-bit controller core. On a lookup request it forms a program-memory address. The high part is a page number taken from the instruction operand. The low part is an in-page offset built from the low bits of the data-pointer register D and the accumulator A. While it fetches that word, the block takes over the program counter. It saves the counter on one level of the return stack and then reads the 10-bit word through a synchronous ROM port. The low byte of the word goes to registers B and A. If the update flag is set, the two top bits reload part of D. Finally the counter is restored from the stack and the stack level is released.

The block owns the return stack. Calls and returns from the core arrive as push and pop requests, and their pc_cur values are stored on the same stack. The block also performs the single-cycle byte-to-nibble transfers that copy a timer, prescaler or E register into B and A. Register writes leave the block as write enables with next values, so the core keeps its own register file.

Top module: `rom_lookup_seq`

## Requirements
- R1: While reset is asserted, and after it is released, busy, rom_en, pc_ovr, a_wr, b_wr, d_wr, stk_ovf and page_err are all 0.
- R2: In the cycle after a lookup is accepted, rom_en is 1 and rom_addr is {effective page, D[2:0], A[3:0]}. The page is in bits 13:7, D in bits 6:4 and A in bits 3:0. A and D are sampled in the accept cycle.
- R3: In the third busy cycle, a_wr and b_wr are 1 with a_nxt = word[3:0] and b_nxt = word[7:4]. Here word is the ROM data returned for the cycle-1 address.
- R4: In the third busy cycle, d_wr equals the update flag sampled at accept. When d_wr is 1, d_nxt = {0, word[9:8]}.
- R5: busy is 1 for exactly three cycles after an accept. Lookup and transfer requests made while busy are ignored.
- R6: pc_ovr is 1 while busy. pc_out shows the fetch address in the first two busy cycles and the saved pc_cur in the third.
- R7: A lookup leaves the stack as it found it: stack_top is the same before and after.
- R8: A transfer with xfer_sel 0 (timer), 1 (prescaler) or 2 (E) writes source[7:4] to B and source[3:0] to A in the same cycle. Selector 3 writes nothing. A lookup request in the same cycle takes priority, and then no transfer write occurs.
- R9: The stack has 8 levels. A push, from the core or from a lookup, while all 8 are in use sets the sticky flag stk_ovf. A lookup made with a full stack still restores pc_cur correctly.
- R10: A page of 96 or more is reduced to page & 63 and sets the sticky flag page_err. Pages up to 95 pass unchanged.
- R11: A core push makes stack_top equal to pc_cur. A core pop exposes the entry below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_lookup | input | 1 | Start a table read |
| lk_page | input | 7 | Page operand |
| uptf | input | 1 | Reload D from word bits 9:8 |
| a_reg | input | 4 | Current A register |
| d_reg | input | 3 | Current D register |
| pc_cur | input | 14 | Current program counter |
| core_push | input | 1 | Core call push of pc_cur |
| core_pop | input | 1 | Core return pop |
| req_xfer | input | 1 | Byte-to-nibble transfer request |
| xfer_sel | input | 2 | Transfer source select |
| tmr2_val | input | 8 | Timer 2 value |
| psc_val | input | 8 | Prescaler value |
| ereg_val | input | 8 | E register value |
| rom_en | output | 1 | ROM read strobe |
| rom_addr | output | 14 | ROM address |
| rom_data | input | 10 | ROM word, one cycle after rom_en |
| busy | output | 1 | Lookup in progress |
| pc_ovr | output | 1 | PC override valid |
| pc_out | output | 14 | Override PC value |
| a_wr | output | 1 | Write A |
| a_nxt | output | 4 | New A value |
| b_wr | output | 1 | Write B |
| b_nxt | output | 4 | New B value |
| d_wr | output | 1 | Write D |
| d_nxt | output | 3 | New D value |
| stack_top | output | 14 | Top stack entry |
| stk_ovf | output | 1 | Sticky stack overflow |
| page_err | output | 1 | Sticky page range error |

## Verification
The bench changes A, D and the page operand after the accept cycle. A design that does not latch them would then fetch from a drifting address. It keeps the request asserted through the busy window, which catches a design that starts a second lookup with a fourth busy cycle. It fills all eight stack levels before a lookup, so a design that restores the counter from the wrong slot, or that loses the overflow, shows a wrong pc_out or a clear flag. Pages 95, 100 and 127 probe the clamp boundary, where an off-by-one compare would raise or miss page_err.

// File: rtl/lkp_pkg.sv
package lkp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_DATA  = 2'd2,
    ST_WRITE = 2'd3
  } lkp_state_t;

  typedef enum logic [1:0] {
    XF_TMR2  = 2'd0,
    XF_PRESC = 2'd1,
    XF_EREG  = 2'd2,
    XF_NONE  = 2'd3
  } xfer_sel_t;

  localparam int NIB_W = 4;
endpackage

// File: rtl/lkp_addr.sv
module lkp_addr #(
  parameter int NUM_PAGES = 96,
  parameter int PAGE_W    = 7,
  parameter int D_BITS    = 3,
  parameter int OFF_W     = D_BITS + lkp_pkg::NIB_W
) (
  input  logic [PAGE_W-1:0]         page_raw,
  input  logic [D_BITS-1:0]         d_val,
  input  logic [lkp_pkg::NIB_W-1:0] a_val,
  output logic [PAGE_W+OFF_W-1:0]   addr,
  output logic                      bad_page
);
  logic [PAGE_W-1:0] page_eff;

  generate
    if (NUM_PAGES >= (1 << PAGE_W)) begin : g_full
      assign page_eff = page_raw;
      assign bad_page = 1'b0;
    end else begin : g_clamp
      localparam int FOLD_BITS = $clog2(NUM_PAGES) - 1;
      localparam logic [PAGE_W-1:0] FOLD_MASK = PAGE_W'((1 << FOLD_BITS) - 1);
      localparam logic [PAGE_W-1:0] PAGE_LIM  = PAGE_W'(NUM_PAGES);
      always_comb begin
        bad_page = (page_raw >= PAGE_LIM);
        page_eff = bad_page ? (page_raw & FOLD_MASK) : page_raw;
      end
    end
  endgenerate

  assign addr = {page_eff, d_val, a_val};
endmodule

// File: rtl/lkp_stack.sv
module lkp_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_val,
  output logic [W-1:0] top,
  output logic         ovf
);
  localparam int SP_W = $clog2(DEPTH);
  localparam logic [SP_W:0] LVL_FULL = (SP_W+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [SP_W-1:0] sp_q, sp_d, sp_inc;
  logic [SP_W:0]   lvl_q, lvl_d;
  logic            ovf_q, ovf_d;
  logic            wrap_q, wrap_d;

  assign sp_inc = sp_q + 1'b1;

  always_comb begin
    sp_d   = sp_q;
    lvl_d  = lvl_q;
    ovf_d  = ovf_q;
    wrap_d = wrap_q;
    if (push) begin
      sp_d = sp_inc;
      if (lvl_q == LVL_FULL) begin
        ovf_d  = 1'b1;
        wrap_d = 1'b1;
      end else begin
        lvl_d = lvl_q + 1'b1;
      end
    end else if (pop) begin
      sp_d = sp_q - 1'b1;
      if (wrap_q) begin
        wrap_d = 1'b0;
      end else if (lvl_q != '0) begin
        lvl_d = lvl_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q   <= '1;
      lvl_q  <= '0;
      ovf_q  <= 1'b0;
      wrap_q <= 1'b0;
    end else begin
      sp_q   <= sp_d;
      lvl_q  <= lvl_d;
      ovf_q  <= ovf_d;
      wrap_q <= wrap_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem[sp_inc] <= push_val;
    end
  end

  assign top = mem[sp_q];
  assign ovf = ovf_q;
endmodule

// File: rtl/lkp_ctrl.sv
module lkp_ctrl
  import lkp_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_lookup,
  input  logic              uptf,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              bad_page,
  input  logic [WORD_W-1:0] rom_data,
  output lkp_state_t        state,
  output logic              accept,
  output logic [ADDR_W-1:0] lat_addr,
  output logic              lat_uptf,
  output logic [WORD_W-1:0] rdata,
  output logic              page_err
);
  lkp_state_t state_q, state_d;
  logic       perr_q, perr_d;

  assign accept = (state_q == ST_IDLE) && req_lookup;

  always_comb begin
    state_d = state_q;
    perr_d  = perr_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_lookup) begin
          state_d = ST_ADDR;
          if (bad_page) perr_d = 1'b1;
        end
      end
      ST_ADDR:  state_d = ST_DATA;
      ST_DATA:  state_d = ST_WRITE;
      ST_WRITE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      perr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      perr_q  <= perr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      lat_addr <= addr_in;
      lat_uptf <= uptf;
    end
    if (state_q == ST_DATA) begin
      rdata <= rom_data;
    end
  end

  assign state    = state_q;
  assign page_err = perr_q;
endmodule

// File: rtl/rom_lookup_seq.sv
module rom_lookup_seq
  import lkp_pkg::*;
#(
  parameter int NUM_PAGES   = 96,
  parameter int PAGE_W      = 7,
  parameter int D_BITS      = 3,
  parameter int WORD_W      = 10,
  parameter int STACK_DEPTH = 8,
  localparam int ADDR_W     = PAGE_W + D_BITS + NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_lookup,
  input  logic [PAGE_W-1:0] lk_page,
  input  logic              uptf,
  input  logic [NIB_W-1:0]  a_reg,
  input  logic [D_BITS-1:0] d_reg,
  input  logic [ADDR_W-1:0] pc_cur,
  input  logic              core_push,
  input  logic              core_pop,
  input  logic              req_xfer,
  input  logic [1:0]        xfer_sel,
  input  logic [7:0]        tmr2_val,
  input  logic [7:0]        psc_val,
  input  logic [7:0]        ereg_val,
  output logic              rom_en,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [WORD_W-1:0] rom_data,
  output logic              busy,
  output logic              pc_ovr,
  output logic [ADDR_W-1:0] pc_out,
  output logic              a_wr,
  output logic [NIB_W-1:0]  a_nxt,
  output logic              b_wr,
  output logic [NIB_W-1:0]  b_nxt,
  output logic              d_wr,
  output logic [D_BITS-1:0] d_nxt,
  output logic [ADDR_W-1:0] stack_top,
  output logic              stk_ovf,
  output logic              page_err
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic [ADDR_W-1:0] fetch_addr;
  logic              bad_page;
  lkp_state_t        state;
  logic              accept;
  logic [ADDR_W-1:0] lat_addr;
  logic              lat_uptf;
  logic [WORD_W-1:0] rdata;
  logic              stk_push, stk_pop;
  logic              idle_free;
  logic [7:0]        xfer_src;
  logic              xfer_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  lkp_addr #(
    .NUM_PAGES(NUM_PAGES), .PAGE_W(PAGE_W), .D_BITS(D_BITS)
  ) u_addr (
    .page_raw(lk_page), .d_val(d_reg), .a_val(a_reg),
    .addr(fetch_addr), .bad_page(bad_page)
  );

  lkp_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .req_lookup(req_lookup), .uptf(uptf),
    .addr_in(fetch_addr), .bad_page(bad_page), .rom_data(rom_data),
    .state(state), .accept(accept), .lat_addr(lat_addr),
    .lat_uptf(lat_uptf), .rdata(rdata), .page_err(page_err)
  );

  assign idle_free = (state == ST_IDLE) && !req_lookup;
  assign stk_push  = accept || (idle_free && core_push);
  assign stk_pop   = (state == ST_WRITE) || (idle_free && !core_push && core_pop);

  lkp_stack #(.DEPTH(STACK_DEPTH), .W(ADDR_W)) u_stack (
    .clk(clk), .rst_n(rst_int_n), .push(stk_push), .pop(stk_pop),
    .push_val(pc_cur), .top(stack_top), .ovf(stk_ovf)
  );

  assign busy     = (state != ST_IDLE);
  assign rom_en   = (state == ST_ADDR);
  assign rom_addr = lat_addr;
  assign pc_ovr   = busy;
  assign pc_out   = (state == ST_WRITE) ? stack_top : lat_addr;

  always_comb begin
    unique case (xfer_sel)
      XF_TMR2:  xfer_src = tmr2_val;
      XF_PRESC: xfer_src = psc_val;
      default:  xfer_src = ereg_val;
    endcase
  end
  assign xfer_go = idle_free && req_xfer && (xfer_sel != XF_NONE);

  always_comb begin
    a_wr  = 1'b0;
    b_wr  = 1'b0;
    a_nxt = '0;
    b_nxt = '0;
    d_wr  = 1'b0;
    d_nxt = '0;
    if (state == ST_WRITE) begin
      a_wr  = 1'b1;
      b_wr  = 1'b1;
      a_nxt = rdata[3:0];
      b_nxt = rdata[7:4];
      d_wr  = lat_uptf;
      d_nxt = {{(D_BITS-2){1'b0}}, rdata[9:8]};
    end else if (xfer_go) begin
      a_wr  = 1'b1;
      b_wr  = 1'b1;
      a_nxt = xfer_src[3:0];
      b_nxt = xfer_src[7:4];
    end
  end
endmodule

// File: rtl/lkp_checker.sv
module lkp_checker #(
  parameter int ADDR_W = 14,
  parameter int D_BITS = 3,
  parameter int WORD_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              rom_en,
  input logic [ADDR_W-1:0] rom_addr,
  input logic [3:0]        a_reg,
  input logic [D_BITS-1:0] d_reg,
  input logic [WORD_W-1:0] rom_data,
  input logic              a_wr,
  input logic [3:0]        a_nxt,
  input logic              d_wr,
  input logic [D_BITS-1:0] d_nxt,
  input logic              pc_ovr,
  input logic [ADDR_W-1:0] pc_out,
  input logic              stk_ovf,
  input logic              page_err
);
  assert_fetch_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en |-> rom_addr[D_BITS+3:0] == $past({d_reg, a_reg}));

  assert_low_nibble_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_wr && busy) |-> a_nxt == $past(rom_data[3:0]));

  assert_d_top_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    d_wr |-> (busy && d_nxt[D_BITS-1] == 1'b0));

  assert_three_cycles_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(busy, 2)) |=> !busy);

  assert_strobe_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en |-> (busy && !$past(busy)));

  assert_pc_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en |-> (pc_ovr && pc_out == rom_addr));

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stk_ovf) |-> stk_ovf);

  assert_perr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(page_err) |-> page_err);
endmodule

bind rom_lookup_seq lkp_checker #(
  .ADDR_W(ADDR_W), .D_BITS(D_BITS), .WORD_W(WORD_W)
) u_chk (
  .clk(clk), .rst_n(rst_int_n), .busy(busy), .rom_en(rom_en),
  .rom_addr(rom_addr), .a_reg(a_reg), .d_reg(d_reg), .rom_data(rom_data),
  .a_wr(a_wr), .a_nxt(a_nxt), .d_wr(d_wr), .d_nxt(d_nxt),
  .pc_ovr(pc_ovr), .pc_out(pc_out), .stk_ovf(stk_ovf), .page_err(page_err)
);

// File: tb/rom_lookup_seq_test.sv
`timescale 1ns/1ps
module rom_lookup_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_lookup = 1'b0;
  logic [6:0]  lk_page = '0;
  logic        uptf = 1'b0;
  logic [3:0]  a_reg = '0;
  logic [2:0]  d_reg = '0;
  logic [13:0] pc_cur = '0;
  logic        core_push = 1'b0;
  logic        core_pop = 1'b0;
  logic        req_xfer = 1'b0;
  logic [1:0]  xfer_sel = '0;
  logic [7:0]  tmr2_val = 8'hA5;
  logic [7:0]  psc_val = 8'h3C;
  logic [7:0]  ereg_val = 8'h7E;
  logic        rom_en;
  logic [13:0] rom_addr;
  logic [9:0]  rom_q = '0;
  logic        busy, pc_ovr, a_wr, b_wr, d_wr, stk_ovf, page_err;
  logic [13:0] pc_out, stack_top;
  logic [3:0]  a_nxt, b_nxt;
  logic [2:0]  d_nxt;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rom_lookup_seq uut (
    .clk(clk), .rst_n(rst_n), .req_lookup(req_lookup), .lk_page(lk_page),
    .uptf(uptf), .a_reg(a_reg), .d_reg(d_reg), .pc_cur(pc_cur),
    .core_push(core_push), .core_pop(core_pop), .req_xfer(req_xfer),
    .xfer_sel(xfer_sel), .tmr2_val(tmr2_val), .psc_val(psc_val),
    .ereg_val(ereg_val), .rom_en(rom_en), .rom_addr(rom_addr),
    .rom_data(rom_q), .busy(busy), .pc_ovr(pc_ovr), .pc_out(pc_out),
    .a_wr(a_wr), .a_nxt(a_nxt), .b_wr(b_wr), .b_nxt(b_nxt), .d_wr(d_wr),
    .d_nxt(d_nxt), .stack_top(stack_top), .stk_ovf(stk_ovf),
    .page_err(page_err)
  );

  function automatic logic [9:0] rom_fn(input logic [13:0] ad);
    return 10'((ad * 14'd13) ^ (ad >> 2) ^ 14'h15A);
  endfunction

  always_ff @(posedge clk) begin
    if (rom_en) rom_q <= rom_fn(rom_addr);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // vector: {uptf, page[6:0], d[2:0], a[3:0]}
  localparam logic [14:0] VEC [6] = '{
    {1'b1, 7'd0,  3'd0, 4'h0},
    {1'b0, 7'd5,  3'd7, 4'hF},
    {1'b1, 7'd63, 3'd2, 4'h9},
    {1'b1, 7'd95, 3'd5, 4'h3},
    {1'b0, 7'd64, 3'd1, 4'hA},
    {1'b1, 7'd17, 3'd6, 4'hC}
  };

  task automatic run_lookup(input logic [14:0] v, input logic [13:0] pc, input bit hold);
    logic [6:0]  pg;
    logic [6:0]  pe;
    logic [13:0] ad;
    logic [9:0]  w;
    logic [13:0] top0;
    pg = v[13:7];
    pe = (pg >= 7'd96) ? (pg & 7'd63) : pg;
    ad = {pe, v[6:0]};
    w  = rom_fn(ad);
    top0 = stack_top;
    @(negedge clk);
    req_lookup = 1'b1; lk_page = pg; uptf = v[14];
    d_reg = v[6:4]; a_reg = v[3:0]; pc_cur = pc;
    @(negedge clk);
    if (!hold) req_lookup = 1'b0;
    lk_page = ~pg; a_reg = ~v[3:0]; d_reg = ~v[6:4]; uptf = ~v[14]; pc_cur = ~pc;
    chk("R5 busy c1", 32'(busy), 1);
    chk("R2 rom_en", 32'(rom_en), 1);
    chk("R2 rom_addr", 32'(rom_addr), 32'(ad));
    chk("R6 pc fetch", 32'({pc_ovr, pc_out}), 32'({1'b1, ad}));
    @(negedge clk);
    req_xfer = 1'b1; xfer_sel = 2'd0;
    #1;
    chk("R5 busy c2", 32'(busy), 1);
    chk("R5 xfer ignored", 32'(a_wr), 0);
    @(negedge clk);
    req_xfer = 1'b0;
    #1;
    chk("R3 wr", 32'({a_wr, b_wr}), 32'b11);
    chk("R3 a_nxt", 32'(a_nxt), 32'(w[3:0]));
    chk("R3 b_nxt", 32'(b_nxt), 32'(w[7:4]));
    chk("R4 d_wr", 32'(d_wr), 32'(v[14]));
    if (v[14]) chk("R4 d_nxt", 32'(d_nxt), 32'({1'b0, w[9:8]}));
    chk("R6 pc restore", 32'({pc_ovr, pc_out}), 32'({1'b1, pc}));
    @(negedge clk);
    req_lookup = 1'b0;
    chk("R5 idle after", 32'(busy), 0);
    chk("R7 stack kept", 32'(stack_top), 32'(top0));
  endtask

  task automatic push_pc(input logic [13:0] val);
    @(negedge clk);
    core_push = 1'b1; pc_cur = val;
    @(negedge clk);
    core_push = 1'b0;
    chk("R11 push top", 32'(stack_top), 32'(val));
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R1 in reset", 32'({busy, rom_en, pc_ovr, a_wr, b_wr, d_wr, stk_ovf, page_err}), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after reset", 32'({busy, rom_en, pc_ovr, a_wr, b_wr, d_wr, stk_ovf, page_err}), 0);

    push_pc(14'h0ABC);

    for (int i = 0; i < 6; i++) begin
      run_lookup(VEC[i], 14'h1000 + 14'(i * 3), (i == 2));
    end
    chk("R10 no err <=95", 32'(page_err), 0);

    // R8 transfers
    @(negedge clk);
    req_xfer = 1'b1; xfer_sel = 2'd0; #1;
    chk("R8 timer", 32'({a_wr, b_wr, b_nxt, a_nxt}), 32'({2'b11, 8'hA5}));
    xfer_sel = 2'd1; #1;
    chk("R8 prescaler", 32'({a_wr, b_wr, b_nxt, a_nxt}), 32'({2'b11, 8'h3C}));
    xfer_sel = 2'd2; #1;
    chk("R8 ereg", 32'({a_wr, b_wr, b_nxt, a_nxt}), 32'({2'b11, 8'h7E}));
    xfer_sel = 2'd3; #1;
    chk("R8 none", 32'({a_wr, b_wr}), 0);
    xfer_sel = 2'd0; req_lookup = 1'b1; lk_page = 7'd3; #1;
    chk("R8 lookup priority", 32'({a_wr, b_wr}), 0);
    @(negedge clk);
    req_lookup = 1'b0; req_xfer = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 back idle", 32'(busy), 0);

    // R10 clamp
    run_lookup({1'b1, 7'd100, 3'd4, 4'h6}, 14'h2222, 1'b0);
    chk("R10 err set", 32'(page_err), 1);
    run_lookup({1'b0, 7'd127, 3'd3, 4'h1}, 14'h2333, 1'b0);
    chk("R10 err sticky", 32'(page_err), 1);

    // R9 fill the stack: one level in use, add seven
    for (int k = 1; k < 8; k++) push_pc(14'h0100 + 14'(k));
    chk("R9 full no ovf", 32'(stk_ovf), 0);
    run_lookup({1'b1, 7'd9, 3'd2, 4'h4}, 14'h3456, 1'b0);
    chk("R9 ovf set", 32'(stk_ovf), 1);
    @(negedge clk);
    core_pop = 1'b1;
    @(negedge clk);
    core_pop = 1'b0;
    chk("R11 pop", 32'(stack_top), 32'(14'h0106));
    push_pc(14'h0200);
    chk("R9 ovf sticky", 32'(stk_ovf), 1);

    // R1 reset during a lookup
    @(negedge clk);
    req_lookup = 1'b1; lk_page = 7'd1;
    @(negedge clk);
    req_lookup = 1'b0;
    rst_n = 1'b0; #1;
    chk("R1 mid reset", 32'({busy, rom_en, a_wr, stk_ovf, page_err}), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after 2nd reset", 32'({busy, stk_ovf, page_err}), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule